// File: doc/BRIEF.md
# Rate-Scheduled Manchester Frame Transmitter

This block drives a single serial line with Manchester-coded bytes at half its clock rate. With a 2 MHz clock, each bit occupies two clock cycles, which gives about 1 Mbps. It has three sources of frames:

- a stimulation frame, fetched byte by byte from an external frame buffer through an address/data read port;
- a voltage-decrease command sequence, held in a small constant table inside the block;
- a voltage-increase command sequence, held in a second constant table.

Every frame ends at the first byte equal to 255. That byte is never sent.

The stimulation frame can be replayed periodically at one of eight rates, chosen by a 3-bit selector. It can also be requested once with a pulse. Voltage commands are requested by pulses from surrounding control logic, which decides when the supply should move. A requested send is remembered until it has been served.

One transmit state machine waits for work, picks the source, reads one byte, and shifts it out. It repeats the read-and-send loop until the end marker appears.

Top module: `mtx_frame_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state machine returns to idle, `tx_line` goes low and every pending request is dropped. After reset, no frame is sent until a new request arrives.
- R2: Until `frames_ready` has been seen high, nothing is transmitted. Requests made before that point stay pending and are sent once `frames_ready` is high.
- R3: Each byte is sent MSB first as 16 clock cycles. A 1 is sent as one cycle high followed by one cycle low; a 0 is sent as low then high. The line stays low for exactly one cycle between bytes of a frame, and it is low whenever no byte is being shifted.
- R4: A stimulation frame is read from buffer address 0 upward, one byte per read. It stops at the first byte equal to 255, which is not sent. Every new stimulation frame restarts at address 0.
- R5: When `periodic_en` is 1, a stimulation frame is started once per period. `rate_sel` 0 to 7 selects 30, 60, 100, 200, 300, 500, 1000 and 2000 Hz. The period in clock cycles is PRESCALE × floor(CLK_HZ / (PRESCALE × rate)).
- R6: With `periodic_en` low, a one-cycle pulse on `stim_req` sends the stimulation frame exactly once.
- R7: A pulse on `vdec_req` sends the bytes 0xA5, 0x5A, 0x01, 0x0D, 0x00, 0x3C. These come from a 7-entry table whose last entry is 0xFF.
- R8: A pulse on `vinc_req` sends the bytes 0xA5, 0x5A, 0x02, 0x0E, 0x00, 0x4B. These come from a 7-entry table whose last entry is 0xFF.
- R9: Pending requests are served one frame at a time, in the order increase, then decrease, then stimulation. A request that loses stays pending and is served afterwards, including a request that arrives while a frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per Manchester bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frames_ready | input | 1 | Frame buffer holds a complete frame; lets the machine leave idle |
| periodic_en | input | 1 | Enables periodic replay of the stimulation frame |
| rate_sel | input | 3 | Replay rate select (30 Hz to 2000 Hz) |
| stim_req | input | 1 | One-cycle pulse requesting one stimulation frame |
| vdec_req | input | 1 | One-cycle pulse requesting the voltage-decrease sequence |
| vinc_req | input | 1 | One-cycle pulse requesting the voltage-increase sequence |
| buf_addr | output | BUF_AW | Read address into the external frame buffer |
| buf_data | input | 8 | Buffer read data, valid combinationally for `buf_addr` |
| tx_line | output | 1 | Manchester-coded serial output |

## Verification
The bench targets the following corner cases:

- **Simultaneous requests.** All three requests are raised in the same cycle, and requests are also raised while another frame is on the line. A wrong arbiter would reorder the frames or lose the one that lost arbitration.
- **Terminator handling.** The bench checks that the 255 terminator never appears on the line and that a second frame repeats the first byte for byte. A design that sent the terminator, or failed to rewind the buffer address, would produce extra or shifted bytes.
- **Replay rates.** Each of the eight rates is measured as the distance between consecutive frame starts. An off-by-one in the prescaler or period counter shows up as a period one tick too long or too short.
- **Zero-valued bytes.** A 0x00 byte in the middle of a frame must not be mistaken for idle.
- **Reset during a transfer.** Reset is applied in the middle of a transfer; the line must drop at once and no leftover request may be replayed.

// File: rtl/mtx_pkg.sv
// Package: shared state type, constants and the rate list for the Manchester
// frame transmitter. Assumes eight selectable replay rates.
package mtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_RD_STIM = 3'd2,
        ST_RD_VADJ = 3'd3,
        ST_TX      = 3'd4
    } mtx_state_e;

    localparam int          RATE_COUNT = 8;
    localparam int          CMD_DEPTH  = 7;
    localparam logic [7:0]  END_BYTE   = 8'hFF;

    // Replay rate in Hz for a selector value.
    function automatic int rate_hz(input int sel);
        case (sel)
            0:       return 30;
            1:       return 60;
            2:       return 100;
            3:       return 200;
            4:       return 300;
            5:       return 500;
            6:       return 1000;
            default: return 2000;
        endcase
    endfunction

endpackage

// File: rtl/mtx_rate_timer.sv
// Rate timer: a prescaler followed by a period counter. Emits a one-cycle
// 'due' pulse every PRESCALE * reload cycles while 'run' is high.
// Assumes: reload values fit in CNT_W bits; 'run' low holds the timer cleared.
module mtx_rate_timer
    import mtx_pkg::*;
#(
    parameter int CLK_HZ   = 2_000_000,
    parameter int PRESCALE = 32,
    parameter int CNT_W    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] rate_sel,
    output logic       due
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [CNT_W-1:0] reload_tab [RATE_COUNT];
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] target_m1;
    logic             tick;

    // One reload constant per selectable rate.
    for (genvar g = 0; g < RATE_COUNT; g++) begin : g_reload
        localparam int TICKS = CLK_HZ / (PRESCALE * rate_hz(g));
        assign reload_tab[g] = CNT_W'(TICKS);
    end

    assign target_m1 = reload_tab[rate_sel] - CNT_W'(1);
    assign tick      = (pre_q == PRE_W'(PRESCALE - 1));
    assign due       = run && tick && (cnt_q >= target_m1);

    // Prescaler and period counter advance together; cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (cnt_q >= target_m1) cnt_q <= '0;
            else                    cnt_q <= cnt_q + CNT_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

endmodule

// File: rtl/mtx_cmd_rom.sv
// Command tables: two constant 7-entry byte sequences (voltage decrease and
// voltage increase), each ending in the 0xFF marker. Pure combinational read.
module mtx_cmd_rom (
    input  logic       sel_inc,
    input  logic [2:0] idx,
    output logic [7:0] data
);

    // Table lookup, increase table in the upper half.
    always_comb begin
        case ({sel_inc, idx})
            4'b0_000: data = 8'hA5;
            4'b0_001: data = 8'h5A;
            4'b0_010: data = 8'h01;
            4'b0_011: data = 8'h0D;
            4'b0_100: data = 8'h00;
            4'b0_101: data = 8'h3C;
            4'b1_000: data = 8'hA5;
            4'b1_001: data = 8'h5A;
            4'b1_010: data = 8'h02;
            4'b1_011: data = 8'h0E;
            4'b1_100: data = 8'h00;
            4'b1_101: data = 8'h4B;
            default:  data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/mtx_serializer.sv
// Serializer: loads a byte and shifts it out MSB first as Manchester halves,
// first half = bit value, second half = its inverse, one cycle per half.
// Assumes 'load' is only raised when the previous byte has finished.
module mtx_serializer (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    output logic       line,
    output logic       last,
    output logic       second
);

    logic [7:0] sh_q;
    logic [2:0] bit_q;
    logic       second_q;
    logic       active_q;
    logic       line_q;

    assign line   = line_q;
    assign second = active_q && second_q;
    assign last   = active_q && second_q && (bit_q == 3'd7);

    // Shift register, half-bit phase and registered line output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q     <= '0;
            bit_q    <= '0;
            second_q <= 1'b0;
            active_q <= 1'b0;
            line_q   <= 1'b0;
        end else if (load) begin
            sh_q     <= din;
            bit_q    <= '0;
            second_q <= 1'b0;
            active_q <= 1'b1;
            line_q   <= din[7];
        end else if (active_q) begin
            if (!second_q) begin
                second_q <= 1'b1;
                line_q   <= ~sh_q[7];
            end else if (bit_q == 3'd7) begin
                second_q <= 1'b0;
                active_q <= 1'b0;
                line_q   <= 1'b0;
            end else begin
                second_q <= 1'b0;
                bit_q    <= bit_q + 3'd1;
                sh_q     <= {sh_q[6:0], 1'b0};
                line_q   <= sh_q[6];
            end
        end
    end

endmodule

// File: rtl/mtx_frame_tx.sv
// Top: one transmit state machine serving three frame sources (buffered
// stimulation frame, voltage-decrease and voltage-increase tables). It
// arbitrates pending requests (increase > decrease > stimulation), reads one
// byte per step and serializes it, and ends each frame at 0xFF (not sent).
// Assumes buf_data is a combinational read of buf_addr.
module mtx_frame_tx
    import mtx_pkg::*;
#(
    parameter int CLK_HZ   = 2_000_000,
    parameter int PRESCALE = 32,
    parameter int CNT_W    = 16,
    parameter int BUF_AW   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frames_ready,
    input  logic              periodic_en,
    input  logic [2:0]        rate_sel,
    input  logic              stim_req,
    input  logic              vdec_req,
    input  logic              vinc_req,
    output logic [BUF_AW-1:0] buf_addr,
    input  logic [7:0]        buf_data,
    output logic              tx_line
);

    localparam int PTR_W = $clog2(CMD_DEPTH);

    mtx_state_e        state_q, state_d;
    logic [BUF_AW-1:0] addr_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              inc_sel_q;
    logic              stim_pend_q, vdec_pend_q, vinc_pend_q;
    logic              due, take_inc, take_dec, take_stim;
    logic              ser_load, ser_last, ser_second;
    logic [7:0]        rom_byte, ser_din;

    mtx_rate_timer #(
        .CLK_HZ  (CLK_HZ),
        .PRESCALE(PRESCALE),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (periodic_en && (state_q != ST_IDLE)),
        .rate_sel(rate_sel),
        .due     (due)
    );

    mtx_cmd_rom u_rom (
        .sel_inc(inc_sel_q),
        .idx    (ptr_q),
        .data   (rom_byte)
    );

    mtx_serializer u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ser_load),
        .din   (ser_din),
        .line  (tx_line),
        .last  (ser_last),
        .second(ser_second)
    );

    assign buf_addr  = addr_q;
    assign take_inc  = (state_q == ST_WAIT) && vinc_pend_q;
    assign take_dec  = (state_q == ST_WAIT) && !vinc_pend_q && vdec_pend_q;
    assign take_stim = (state_q == ST_WAIT) && !vinc_pend_q && !vdec_pend_q && stim_pend_q;
    assign ser_load  = ((state_q == ST_RD_STIM) && (buf_data != END_BYTE)) ||
                       ((state_q == ST_RD_VADJ) && (rom_byte != END_BYTE));
    assign ser_din   = (state_q == ST_RD_STIM) ? buf_data : rom_byte;

    // Next-state selection for the transmit machine.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:    if (frames_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (take_inc || take_dec) state_d = ST_RD_VADJ;
                else if (take_stim)       state_d = ST_RD_STIM;
            end
            ST_RD_STIM: state_d = (buf_data == END_BYTE) ? ST_WAIT : ST_TX;
            ST_RD_VADJ: state_d = (rom_byte == END_BYTE) ? ST_WAIT : ST_TX;
            ST_TX: begin
                if (ser_last) state_d = (state_q == ST_TX && src_vadj()) ? ST_RD_VADJ : ST_RD_STIM;
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // Which source the current frame comes from.
    logic src_vadj_q;
    function automatic logic src_vadj();
        return src_vadj_q;
    endfunction

    // State, source, read pointers and pending request flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            ptr_q       <= '0;
            inc_sel_q   <= 1'b0;
            src_vadj_q  <= 1'b0;
            stim_pend_q <= 1'b0;
            vdec_pend_q <= 1'b0;
            vinc_pend_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            stim_pend_q <= (stim_pend_q && !take_stim) || due || stim_req;
            vdec_pend_q <= (vdec_pend_q && !take_dec)  || vdec_req;
            vinc_pend_q <= (vinc_pend_q && !take_inc)  || vinc_req;
            if (take_inc || take_dec) begin
                src_vadj_q <= 1'b1;
                inc_sel_q  <= take_inc;
                ptr_q      <= '0;
            end else if (take_stim) begin
                src_vadj_q <= 1'b0;
                addr_q     <= '0;
            end
            if (ser_load && state_q == ST_RD_STIM) addr_q <= addr_q + BUF_AW'(1);
            if (ser_load && state_q == ST_RD_VADJ) ptr_q  <= ptr_q + PTR_W'(1);
        end
    end

endmodule

// File: rtl/mtx_frame_tx_chk.sv
// Checker for mtx_frame_tx: protocol and arbitration properties, bound to
// the top module below.
module mtx_frame_tx_chk
    import mtx_pkg::*;
#(
    parameter int BUF_AW = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frames_ready,
    input mtx_state_e        state,
    input logic              tx_line,
    input logic              ser_second,
    input logic [BUF_AW-1:0] buf_addr,
    input logic              vinc_pend,
    input logic              vdec_pend,
    input logic              stim_pend,
    input logic              inc_sel
);

    // R1: a reset edge leaves the machine idle with a quiet line
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !tx_line));

    // R2: idle is held while the buffer is not ready
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !frames_ready) |=> state == ST_IDLE);

    // R3: second half of every bit inverts the first half
    assert_half_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_second |-> tx_line != $past(tx_line));

    // R3: the line is low whenever no byte is being shifted
    assert_line_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_TX) |-> !tx_line);

    // R4: a new stimulation frame starts at buffer address 0
    assert_addr_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_STIM && $past(state) == ST_WAIT) |-> buf_addr == '0);

    // R9: a pending increase wins arbitration
    assert_inc_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && vinc_pend) |=> (state == ST_RD_VADJ && inc_sel));

    // R9: decrease beats stimulation when no increase is pending
    assert_dec_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !vinc_pend && vdec_pend) |=> (state == ST_RD_VADJ && !inc_sel));

    // R9: a losing stimulation request stays pending
    assert_stim_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && (vinc_pend || vdec_pend) && stim_pend) |=> stim_pend);

endmodule

bind mtx_frame_tx mtx_frame_tx_chk #(.BUF_AW(BUF_AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frames_ready(frames_ready),
    .state       (state_q),
    .tx_line     (tx_line),
    .ser_second  (ser_second),
    .buf_addr    (buf_addr),
    .vinc_pend   (vinc_pend_q),
    .vdec_pend   (vdec_pend_q),
    .stim_pend   (stim_pend_q),
    .inc_sel     (inc_sel_q)
);

// File: tb/sim_mtx_frame_tx.sv
// Bench for mtx_frame_tx: a line monitor decodes Manchester bytes into a
// queue; a rate vector table is walked by one loop, then directed tests.
module sim_mtx_frame_tx;

    localparam int CLK_HZ   = 60000;
    localparam int PRESCALE = 2;
    localparam int BUF_AW   = 10;

    // rate_sel stimulus and expected period in clock cycles (R5)
    localparam int RATE_VEC [8][2] = '{
        '{0, 2000}, '{1, 1000}, '{2, 600}, '{3, 300},
        '{4, 200},  '{5, 120},  '{6, 60},  '{7, 30}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frames_ready = 1'b0;
    logic              periodic_en = 1'b0;
    logic [2:0]        rate_sel = 3'd0;
    logic              stim_req = 1'b0;
    logic              vdec_req = 1'b0;
    logic              vinc_req = 1'b0;
    logic [BUF_AW-1:0] buf_addr;
    logic [7:0]        buf_data;
    logic              tx_line;

    logic [7:0] mem [16];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    assign buf_data = mem[buf_addr[3:0]];

    mtx_frame_tx #(
        .CLK_HZ  (CLK_HZ),
        .PRESCALE(PRESCALE),
        .CNT_W   (16),
        .BUF_AW  (BUF_AW)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frames_ready(frames_ready),
        .periodic_en (periodic_en),
        .rate_sel    (rate_sel),
        .stim_req    (stim_req),
        .vdec_req    (vdec_req),
        .vinc_req    (vinc_req),
        .buf_addr    (buf_addr),
        .buf_data    (buf_data),
        .tx_line     (tx_line)
    );

    // Line monitor: decodes bytes; 9'h100 marks a frame end.
    logic [8:0]  rxq [$];
    int          starts [$];
    int          cyc = 0;
    int          mst = 0;
    int          k = 0;
    logic [15:0] sb;
    logic        f;
    logic [7:0]  bv;
    bit          okb;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            mst = 0;
        end else begin
            case (mst)
                0: if (tx_line) begin
                       sb = '0; sb[15] = 1'b1; k = 1; mst = 1;
                       starts.push_back(cyc);
                   end
                1: begin
                       sb[15-k] = tx_line; k++;
                       if (k == 16) begin
                           okb = 1'b1;
                           for (int i = 0; i < 8; i++) begin
                               if (sb[15-2*i] == sb[14-2*i]) okb = 1'b0;
                               bv[7-i] = sb[15-2*i];
                           end
                           checks++;
                           if (!okb) begin
                               errors++;
                               $display("FAIL R3: bad Manchester pair, actual %h expected complementary halves", sb);
                           end
                           rxq.push_back({1'b0, bv});
                           mst = 2;
                       end
                   end
                2: begin
                       if (tx_line) begin
                           checks++; errors++;
                           $display("FAIL R3: inter-byte gap actual 1 expected 0");
                       end
                       mst = 3;
                   end
                3: begin f = tx_line; mst = 4; end
                default: begin
                       if (!f && !tx_line) begin
                           rxq.push_back(9'h100); mst = 0;
                       end else if (f != tx_line) begin
                           sb = '0; sb[15] = f; sb[14] = tx_line; k = 2; mst = 1;
                       end else begin
                           checks++; errors++;
                           $display("FAIL R3: line held high actual 11 expected pair or idle");
                           mst = 0;
                       end
                   end
            endcase
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_byte(input string req, input logic [8:0] exp);
        logic [8:0] got;
        checks++;
        got = (rxq.size() == 0) ? 9'h1FF : rxq.pop_front();
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic expect_stim(input string req);
        expect_byte(req, 9'h0C3); expect_byte(req, 9'h000);
        expect_byte(req, 9'h07E); expect_byte(req, 9'h100);
    endtask

    task automatic expect_dec(input string req);
        expect_byte(req, 9'h0A5); expect_byte(req, 9'h05A); expect_byte(req, 9'h001);
        expect_byte(req, 9'h00D); expect_byte(req, 9'h000); expect_byte(req, 9'h03C);
        expect_byte(req, 9'h100);
    endtask

    task automatic expect_inc(input string req);
        expect_byte(req, 9'h0A5); expect_byte(req, 9'h05A); expect_byte(req, 9'h002);
        expect_byte(req, 9'h00E); expect_byte(req, 9'h000); expect_byte(req, 9'h04B);
        expect_byte(req, 9'h100);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'hFF;
        mem[0] = 8'hC3; mem[1] = 8'h00; mem[2] = 8'h7E; mem[3] = 8'hFF;
        step(5);
        check("R1 reset line", int'(tx_line), 0);
        rst_n = 1'b1;
        step(2);
        check("R1 line after reset", int'(tx_line), 0);
        check("R1 addr after reset", int'(buf_addr), 0);

        // R2: request before ready is held
        stim_req = 1'b1; step(1); stim_req = 1'b0;
        step(200);
        check("R2 silent before ready", rxq.size(), 0);
        frames_ready = 1'b1;
        step(150);
        expect_stim("R2 pending frame sent");

        // R4: second frame restarts at address 0, 255 not sent
        stim_req = 1'b1; step(1); stim_req = 1'b0;
        step(150);
        expect_stim("R4 repeat frame");

        // R7 and R8: command tables
        vdec_req = 1'b1; step(1); vdec_req = 1'b0;
        step(200);
        expect_dec("R7 decrease sequence");
        vinc_req = 1'b1; step(1); vinc_req = 1'b0;
        step(200);
        expect_inc("R8 increase sequence");

        // R9: simultaneous requests
        stim_req = 1'b1; vdec_req = 1'b1; vinc_req = 1'b1; step(1);
        stim_req = 1'b0; vdec_req = 1'b0; vinc_req = 1'b0;
        step(500);
        expect_inc("R9 first inc");
        expect_dec("R9 then dec");
        expect_stim("R9 then stim");

        // R9: requests arriving while a frame is on the line
        vdec_req = 1'b1; step(1); vdec_req = 1'b0;
        step(10);
        stim_req = 1'b1; vinc_req = 1'b1; step(1);
        stim_req = 1'b0; vinc_req = 1'b0;
        step(500);
        expect_dec("R9 busy dec");
        expect_inc("R9 busy inc");
        expect_stim("R9 busy stim");

        // R6: one-shot send
        starts.delete(); rxq.delete();
        stim_req = 1'b1; step(1); stim_req = 1'b0;
        step(3000);
        check("R6 single frame", starts.size(), 1);
        expect_stim("R6 frame content");

        // R5: rate vector table
        mem[0] = 8'h81; mem[1] = 8'hFF;
        for (int v = 0; v < 8; v++) begin
            periodic_en = 1'b0;
            step(40);
            starts.delete(); rxq.delete();
            rate_sel = 3'(RATE_VEC[v][0]);
            periodic_en = 1'b1;
            for (int w = 0; w < 6 * RATE_VEC[v][1] && starts.size() < 4; w++) step(1);
            periodic_en = 1'b0;
            if (starts.size() < 4) begin
                check("R5 frame count", starts.size(), 4);
            end else begin
                check("R5 period A", starts[2] - starts[1], RATE_VEC[v][1]);
                check("R5 period B", starts[3] - starts[2], RATE_VEC[v][1]);
            end
        end
        step(40);
        rxq.delete();

        // R1: reset in the middle of a transfer
        vdec_req = 1'b1; step(1); vdec_req = 1'b0;
        step(20);
        rst_n = 1'b0;
        step(1);
        check("R1 line drops in reset", int'(tx_line), 0);
        step(2);
        rst_n = 1'b1;
        rxq.delete();
        step(300);
        check("R1 no replay after reset", rxq.size(), 0);

        finish_run();
    end

endmodule